// File: doc/BRIEF.md
# Sub-Vector Swizzle Move Unit

This unit decodes and executes a vector move that permutes the four sub-elements (x, y, z, w) of a sub-vector. Each cycle it may take one 32-bit instruction word with a valid strobe, together with the current sub-vector length setting, the source sub-vector read from rs1, and the value read from rs2. It returns the permuted destination sub-vector, the destination register index and a write enable, all registered.

Two encodings share the vector major opcode. The immediate form carries an 8-bit lane selector in the instruction. The register form either copies plainly or, with a marker in its top field, takes the selector from the low byte of the rs2 value. A selector only acts while the sub-vector length is non-zero; at zero every form is a plain copy. The unit does not touch the register file or the length setting.

Top module: `swz_move_unit`

## Requirements
- R1: An instruction is taken only when `valid_i` is high, `insn_i[6:0]` is 7'b1010111 and `insn_i[14:12]` is 3'b000 (immediate form) or 3'b001 (register form). Any other word, or a low `valid_i`, leaves `we_o` and `illegal_o` low and `dst_o`, `rd_o` unchanged.
- R2: The destination index is `insn_i[11:7]`. In the immediate form the selector byte is `insn_i[27:20]`. Lane 0 (x) is `src_i[W-1:0]`, lane 1 (y) the next W bits, then z, then w. Selector bits [2i+1:2i] give the source lane index for destination lane i.
- R3: When `subvl_i` is zero, the immediate form and the rs2-selector form both copy `src_i` unchanged.
- R4: The register form with `insn_i[31:25]` = 7'b0000000 copies `src_i` for any `subvl_i` and any `rs2_val_i`.
- R5: The register form with `insn_i[31:25]` = 7'b0000001 and non-zero `subvl_i` uses `rs2_val_i[7:0]` as the selector, laid out as in R2. All higher bits of `rs2_val_i` are ignored.
- R6: Several destination lanes may name the same source lane, so a selector of all zeros gives xxxx and 8'hFF gives wwww.
- R7: An immediate form with `insn_i[31:28]` non-zero, or a register form whose `insn_i[31:25]` is neither 0 nor 1, raises `illegal_o` for one cycle. `we_o` stays low and `dst_o` and `rd_o` keep their values.
- R8: The results appear on the clock edge that samples the instruction. `we_o` is high for exactly one cycle for each accepted instruction, so back-to-back instructions give back-to-back pulses.
- R9: While `rst_ni` is low, `we_o`, `illegal_o`, `rd_o` and `dst_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word is present this cycle |
| insn_i | input | 32 | Instruction word |
| subvl_i | input | SUBVL_W | Current sub-vector length setting; zero disables the swizzle |
| src_i | input | 4*ELEM_W | Source sub-vector from rs1, x in the low lane |
| rs2_val_i | input | RS2_W | Value of rs2, low byte is the selector for the rs2-selector form |
| dst_o | output | 4*ELEM_W | Registered destination sub-vector |
| rd_o | output | 5 | Registered destination register index |
| we_o | output | 1 | One-cycle write enable |
| illegal_o | output | 1 | One-cycle illegal-instruction flag |

## Verification
The hardest case to reach is an rs2-selector move whose rs2 value has junk in its upper bits while the instruction's own rs2 and rs1 fields hold other values. A wrong bit slice in the selector path only shows up then. The stimulus table sets those upper bits and uses a selector that differs from the identity and from the immediate byte, so any crossed path gives a visibly wrong lane order. Illegal encodings are placed directly after a legal move with a distinctive result, so that a write that is wrongly let through changes `dst_o` where the bench can see it.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam logic [6:0] OPC_VEC   = 7'b1010111;
  localparam logic [2:0] F3_IMM    = 3'b000;
  localparam logic [2:0] F3_REG    = 3'b001;
  localparam logic [6:0] F7_PLAIN  = 7'b0000000;
  localparam logic [6:0] F7_RS2SEL = 7'b0000001;
  localparam int unsigned LANES    = 4;
  localparam int unsigned IDX_W    = $clog2(LANES);
  localparam int unsigned SEL_W    = LANES * IDX_W;
  // identity: lane i takes lane i
  localparam logic [SEL_W-1:0] SEL_IDENT = 8'hE4;

  typedef struct packed {
    logic             take;
    logic             illegal;
    logic [4:0]       rd;
    logic [SEL_W-1:0] sel;
  } dec_t;
endpackage

// File: rtl/swz_decode.sv
module swz_decode
  import swz_pkg::*;
#(
  parameter int unsigned SUBVL_W = 2
) (
  input  logic               valid_i,
  input  logic [31:0]        insn_i,
  input  logic [SUBVL_W-1:0] subvl_i,
  input  logic [SEL_W-1:0]   rs2_sel_i,
  output dec_t               dec_o
);
  logic       is_vec, is_imm, is_reg, hit;
  logic [6:0] f7;
  logic       bad_imm, bad_reg, want_swz;
  logic [SEL_W-1:0] sel_raw;
  logic       unused_rs1;

  assign unused_rs1 = ^insn_i[19:15];

  assign f7     = insn_i[31:25];
  assign is_vec = (insn_i[6:0] == OPC_VEC);
  assign is_imm = is_vec && (insn_i[14:12] == F3_IMM);
  assign is_reg = is_vec && (insn_i[14:12] == F3_REG);
  assign hit    = valid_i && (is_imm || is_reg);

  assign bad_imm = is_imm && (insn_i[31:28] != 4'd0);
  assign bad_reg = is_reg && (f7 != F7_PLAIN) && (f7 != F7_RS2SEL);

  assign want_swz = (subvl_i != '0) && (is_imm || (f7 == F7_RS2SEL));
  assign sel_raw  = is_imm ? insn_i[27:20] : rs2_sel_i;

  always_comb begin
    dec_o.illegal = hit && (bad_imm || bad_reg);
    dec_o.take    = hit && !(bad_imm || bad_reg);
    dec_o.rd      = insn_i[11:7];
    dec_o.sel     = want_swz ? sel_raw : SEL_IDENT;
  end

  // R7: a flagged word is never also taken
  always_comb begin
    a_r7_take_xor_ill: assert (!(dec_o.take && dec_o.illegal));
  end
endmodule

// File: rtl/swz_xbar.sv
module swz_xbar
  import swz_pkg::*;
#(
  parameter int unsigned ELEM_W = 16
) (
  input  logic [LANES*ELEM_W-1:0] src_i,
  input  logic [SEL_W-1:0]        sel_i,
  output logic [LANES*ELEM_W-1:0] dst_o
);
  logic [ELEM_W-1:0] lane_src [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IDX_W-1:0] idx;
    assign lane_src[g] = src_i[g*ELEM_W +: ELEM_W];
    assign idx         = sel_i[g*IDX_W +: IDX_W];
    assign dst_o[g*ELEM_W +: ELEM_W] = lane_src[idx];
  end

  // R3/R4: identity selector passes the sub-vector through
  always_comb begin
    if (sel_i == SEL_IDENT) a_r3_ident_copy: assert (dst_o == src_i);
  end
endmodule

// File: rtl/swz_move_unit.sv
module swz_move_unit
  import swz_pkg::*;
#(
  parameter int unsigned ELEM_W  = 16,
  parameter int unsigned SUBVL_W = 2,
  parameter int unsigned RS2_W   = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [31:0]             insn_i,
  input  logic [SUBVL_W-1:0]      subvl_i,
  input  logic [LANES*ELEM_W-1:0] src_i,
  input  logic [RS2_W-1:0]        rs2_val_i,
  output logic [LANES*ELEM_W-1:0] dst_o,
  output logic [4:0]              rd_o,
  output logic                    we_o,
  output logic                    illegal_o
);
  localparam int unsigned VEC_W = LANES * ELEM_W;

  dec_t             dec;
  logic [VEC_W-1:0] perm;
  logic             unused_rs2_hi;

  assign unused_rs2_hi = ^rs2_val_i[RS2_W-1:SEL_W];

  swz_decode #(.SUBVL_W(SUBVL_W)) u_dec (
    .valid_i  (valid_i),
    .insn_i   (insn_i),
    .subvl_i  (subvl_i),
    .rs2_sel_i(rs2_val_i[SEL_W-1:0]),
    .dec_o    (dec)
  );

  swz_xbar #(.ELEM_W(ELEM_W)) u_xbar (
    .src_i(src_i),
    .sel_i(dec.sel),
    .dst_o(perm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o      <= 1'b0;
      illegal_o <= 1'b0;
      rd_o      <= '0;
      dst_o     <= '0;
    end else begin
      we_o      <= dec.take;
      illegal_o <= dec.illegal;
      if (dec.take) begin
        rd_o  <= dec.rd;
        dst_o <= perm;
      end
    end
  end

  a_r7_ill_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !we_o);

  a_r8_we_from_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> $past(valid_i));

  a_r7_hold_dst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_o |-> ($stable(dst_o) && $stable(rd_o)));

  a_r3_zero_subvl_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && ($past(subvl_i) == '0)) |-> (dst_o == $past(src_i)));

  a_r1_foreign_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(insn_i[6:0]) != OPC_VEC) |-> (!we_o && !illegal_o));
endmodule

// File: tb/sim_swz_move_unit.sv
`timescale 1ns/1ps
module sim_swz_move_unit;
  localparam int unsigned EW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] insn = '0;
  logic [1:0]  subvl = '0;
  logic [63:0] src = '0;
  logic [63:0] rs2v = '0;
  logic [63:0] dst;
  logic [4:0]  rd;
  logic        we, ill;

  int nchk = 0;
  int nerr = 0;
  logic [63:0] prev_dst;

  always #10 clk = ~clk;

  swz_move_unit #(.ELEM_W(EW), .SUBVL_W(2), .RS2_W(64)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .insn_i(insn),
    .subvl_i(subvl), .src_i(src), .rs2_val_i(rs2v),
    .dst_o(dst), .rd_o(rd), .we_o(we), .illegal_o(ill)
  );

  function automatic logic [31:0] mk_i(logic [3:0] rsv, logic [7:0] sel, logic [4:0] rd_f,
                                       logic [2:0] f3, logic [6:0] opc);
    return {rsv, sel, 5'd9, f3, rd_f, opc};
  endfunction

  function automatic logic [31:0] mk_r(logic [6:0] f7, logic [4:0] rs2_f, logic [4:0] rd_f);
    return {f7, rs2_f, 5'd12, 3'b001, rd_f, 7'b1010111};
  endfunction

  function automatic logic [63:0] model(logic [63:0] s, logic [7:0] sel);
    logic [63:0] r;
    for (int i = 0; i < 4; i++) r[i*EW +: EW] = s[sel[2*i +: 2]*EW +: EW];
    return r;
  endfunction

  typedef struct packed {
    logic [31:0] insn;
    logic [1:0]  subvl;
    logic [63:0] rs2;
    logic        we;
    logic        ill;
    logic [7:0]  sel;
  } vec_t;

  localparam logic [63:0] SRC = 64'h4444_3333_2222_1111;
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{mk_i(4'h0, 8'h1B, 5'd5, 3'b000, 7'h57), 2'd1, 64'h0, 1'b1, 1'b0, 8'h1B},   // R2 reverse
    '{mk_i(4'h0, 8'h1B, 5'd6, 3'b000, 7'h57), 2'd0, 64'h0, 1'b1, 1'b0, 8'hE4},   // R3
    '{mk_i(4'h0, 8'h00, 5'd7, 3'b000, 7'h57), 2'd2, 64'h0, 1'b1, 1'b0, 8'h00},   // R6 xxxx
    '{mk_i(4'h0, 8'hFF, 5'd8, 3'b000, 7'h57), 2'd3, 64'h0, 1'b1, 1'b0, 8'hFF},   // R6 wwww
    '{mk_i(4'h8, 8'h1B, 5'd9, 3'b000, 7'h57), 2'd1, 64'h0, 1'b0, 1'b1, 8'h00},   // R7 rsv
    '{mk_r(7'h00, 5'd27, 5'd10),              2'd1, 64'h1B, 1'b1, 1'b0, 8'hE4},  // R4
    '{mk_r(7'h01, 5'd27, 5'd11),              2'd1, 64'hFFFF_FFFF_FFFF_FF39, 1'b1, 1'b0, 8'h39}, // R5
    '{mk_r(7'h01, 5'd3, 5'd12),               2'd0, 64'h1B, 1'b1, 1'b0, 8'hE4},  // R3 rs2 form
    '{mk_i(4'h0, 8'h72, 5'd13, 3'b000, 7'h57), 2'd1, 64'h0, 1'b1, 1'b0, 8'h72},  // R2
    '{mk_r(7'h02, 5'd1, 5'd14),               2'd1, 64'h1B, 1'b0, 1'b1, 8'h00},  // R7 f7
    '{mk_r(7'h40, 5'd1, 5'd15),               2'd1, 64'h1B, 1'b0, 1'b1, 8'h00},  // R7 f7
    '{mk_i(4'h0, 8'h1B, 5'd16, 3'b000, 7'h33), 2'd1, 64'h0, 1'b0, 1'b0, 8'h00},  // R1 opcode
    '{mk_i(4'h0, 8'h1B, 5'd17, 3'b010, 7'h57), 2'd1, 64'h0, 1'b0, 1'b0, 8'h00}   // R1 funct3
  };

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  task automatic issue(input logic [31:0] i_w, input logic [1:0] sv, input logic [63:0] r2);
    valid = 1'b1; insn = i_w; subvl = sv; rs2v = r2;
  endtask

  initial begin
    src = SRC;
    // R9 reset state
    repeat (2) @(negedge clk);
    chk(we == 0 && ill == 0, "R9", "flags in reset", {62'd0, we, ill}, 64'd0);
    chk(dst == 0 && rd == 0, "R9", "data in reset", dst, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    prev_dst = dst;

    foreach (VECS[k]) begin
      issue(VECS[k].insn, VECS[k].subvl, VECS[k].rs2);
      @(negedge clk);
      valid = 1'b0;
      chk(we == VECS[k].we, "R1/R7/R8", $sformatf("we vec %0d", k), {63'd0, we}, {63'd0, VECS[k].we});
      chk(ill == VECS[k].ill, "R1/R7", $sformatf("illegal vec %0d", k), {63'd0, ill}, {63'd0, VECS[k].ill});
      if (VECS[k].we) begin
        chk(dst == model(SRC, VECS[k].sel), "R2-R6", $sformatf("dst vec %0d", k), dst, model(SRC, VECS[k].sel));
        chk(rd == VECS[k].insn[11:7], "R2", $sformatf("rd vec %0d", k), {59'd0, rd}, {59'd0, VECS[k].insn[11:7]});
        prev_dst = dst;
      end else begin
        chk(dst == prev_dst, "R7", $sformatf("dst held vec %0d", k), dst, prev_dst);
      end
      @(negedge clk);
      chk(we == 0 && ill == 0, "R8", $sformatf("single pulse vec %0d", k), {62'd0, we, ill}, 64'd0);
    end

    // R1: legal word with valid low
    insn = mk_i(4'h0, 8'h1B, 5'd20, 3'b000, 7'h57); subvl = 2'd1;
    @(negedge clk);
    chk(we == 0 && rd != 5'd20, "R1", "valid low ignored", {59'd0, rd}, 64'd0);

    // R8: back-to-back pulses
    issue(mk_i(4'h0, 8'h00, 5'd21, 3'b000, 7'h57), 2'd1, 64'h0);
    @(negedge clk);
    chk(we == 1 && dst == model(SRC, 8'h00), "R8", "first of pair", dst, model(SRC, 8'h00));
    issue(mk_i(4'h0, 8'hAA, 5'd22, 3'b000, 7'h57), 2'd1, 64'h0);
    @(negedge clk);
    valid = 1'b0;
    chk(we == 1 && rd == 5'd22, "R8", "second of pair rd", {59'd0, rd}, 64'd22);
    chk(dst == model(SRC, 8'hAA), "R6", "zzzz", dst, model(SRC, 8'hAA));
    @(negedge clk);
    chk(we == 0, "R8", "pair ends", {63'd0, we}, 64'd0);

    // R9: reset after activity
    rst_n = 1'b0;
    #3;
    chk(dst == 0 && rd == 0 && we == 0 && ill == 0, "R9", "async reset clears", dst, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule